// File: doc/BRIEF.md
# Password-Locked GPIO Register Bank

This block is a memory-mapped general-purpose I/O controller that serves a parameterised number of 32-pin banks over a plain 32-bit register bus. The bus uses word addresses. Output levels never take a written value directly. Software raises pins through a write-one-to-set register and lowers them through a write-one-to-clear register. Each pin has a control word whose lowest bit selects input or output, and that bit drives the pad's output enable.

Every bank starts out locked. A locked bank ignores writes to its set, clear and control registers, but reads still work. Software changes a bank's lock in two steps. It first writes a key word to a shared key register, and the very next write must go to that bank's lock register. The pad inputs reach the input registers through a synchroniser chain, so software always reads stable values.

Top module: `pwgpio_top`

## Requirements
- R1: After reset every bank is locked, so its lock register reads 0xFFFFFFFF. All pad outputs are 0, all pads are inputs with pad_oe low, and every control word reads 1.
- R2: Pin p belongs to bank p>>5 at bit p&31, and drives pad_out[p], pad_oe[p] and pad_in[p].
- R3: Word addresses, for bank b and pin p: output value at 0x000+b, input value at 0x008+b, set at 0x010+b, clear at 0x018+b, control at 0x040+p, lock at 0x140+b, key at 0x148. Writing 0x00A5A501 to the key register and then writing 0 to bank b's lock register unlocks bank b. Writing 0xFFFFFFFF in the same way locks it. A lock register reads 0xFFFFFFFF when its bank is locked and 0 when it is unlocked.
- R4: A key write arms only the next bus write. That next write is consumed whatever it targets. A lock write that is not armed, or that follows a key write with the wrong value, is ignored.
- R5: An armed lock write whose data is neither 0 nor 0xFFFFFFFF leaves the lock unchanged and still uses up the arming.
- R6: In an unlocked bank, each 1 bit written to the set register drives that output high. Bits written as 0 keep their value.
- R7: In an unlocked bank, each 1 bit written to the clear register drives that output low. Bits written as 0 keep their value.
- R8: Bit 0 of a control word is the direction: 1 means input and 0 means output. pad_oe[p] is the inverse of that bit. All other control bits read as 0.
- R9: While a bank is locked, writes to its set, clear and control registers have no effect. Reads of all its registers still work, and other unlocked banks still accept writes.
- R10: The input register reaches the pads through a two-flop synchroniser. Take a pad change made before clock edge k. A read sampled at edge k or at edge k+1 returns the old value. A read sampled at edge k+2 returns the new value.
- R11: bus_rdata is loaded at the edge where bus_rd_en is high and holds otherwise. The set, clear and key registers and unmapped addresses read 0. Writes to the output value register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 9 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32*NUM_BANKS | Pad input levels |
| pad_out | output | 32*NUM_BANKS | Pad output levels |
| pad_oe | output | 32*NUM_BANKS | Pad output enables, high when the pin is an output |

## Verification
The embedded assertions check on every cycle that a locked bank's outputs and directions hold still. They also check that a lock bit changes only one cycle after an armed write, that a non-key write always disarms, that a malformed lock word leaves the locks alone, and that accepted set or clear writes reach their target bits. Only the bench scenarios can show the following: the address map, the per-pin bit mapping across both banks, the order of key and lock writes, and the two-cycle synchroniser delay seen through the registered read port. Those checks need known stimulus and expected read-back values.

// File: rtl/pwgpio_pkg.sv
package pwgpio_pkg;
   localparam int unsigned WORD_W        = 32;
   localparam int unsigned PINS_PER_BANK = 32;
   localparam int unsigned MAX_BANKS     = 8;
   localparam int unsigned ADDR_W        = 9;

   // word addresses of each region base
   localparam logic [ADDR_W-1:0] OUT_BASE  = 9'h000;
   localparam logic [ADDR_W-1:0] IN_BASE   = 9'h008;
   localparam logic [ADDR_W-1:0] SET_BASE  = 9'h010;
   localparam logic [ADDR_W-1:0] CLR_BASE  = 9'h018;
   localparam logic [ADDR_W-1:0] CTRL_BASE = 9'h040;
   localparam logic [ADDR_W-1:0] LOCK_BASE = 9'h140;
   localparam logic [ADDR_W-1:0] KEY_ADDR  = 9'h148;

   localparam logic [WORD_W-1:0] KEY_WORD  = 32'h00A5_A501;
   localparam logic [WORD_W-1:0] LOCK_WORD = 32'hFFFF_FFFF;
   localparam logic [WORD_W-1:0] OPEN_WORD = 32'h0000_0000;
endpackage

// File: rtl/pwgpio_sync.sv
module pwgpio_sync #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwgpio_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pwgpio_lock.sv
module pwgpio_lock
   import pwgpio_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 key_hit,
   input  logic [NUM_BANKS-1:0] lock_hit,
   input  logic [WORD_W-1:0]    wdata,
   output logic [NUM_BANKS-1:0] locked
);
   logic armed_q;

   // any write re-evaluates the arm: only a correct key leaves it set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (wr_en) armed_q <= key_hit && (wdata == KEY_WORD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= '1;
      end else if (wr_en && armed_q) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (lock_hit[b]) begin
               if (wdata == LOCK_WORD)      locked[b] <= 1'b1;
               else if (wdata == OPEN_WORD) locked[b] <= 1'b0;
            end
         end
      end
   end

   AST_LOCK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (locked != $past(locked)) |-> ($past(armed_q) && $past(wr_en))); // R4
   AST_ARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wr_en && !key_hit) |=> !armed_q); // R4
   AST_ODD_WORD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (|lock_hit) && wdata != LOCK_WORD && wdata != OPEN_WORD)
      |=> (locked == $past(locked))); // R5
endmodule

// File: rtl/pwgpio_bank.sv
module pwgpio_bank
   import pwgpio_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     locked,
   input  logic                     set_we,
   input  logic                     clr_we,
   input  logic [PINS_PER_BANK-1:0] ctrl_we,
   input  logic                     ctrl_bit,
   input  logic [WORD_W-1:0]        wdata,
   output logic [PINS_PER_BANK-1:0] out_q,
   output logic [PINS_PER_BANK-1:0] dir_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (!locked) begin
         if (set_we)      out_q <= out_q | wdata;
         else if (clr_we) out_q <= out_q & ~wdata;
      end
   end

   // direction: 1 = input, reset makes every pin an input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '1;
      end else if (!locked) begin
         for (int i = 0; i < PINS_PER_BANK; i++)
            if (ctrl_we[i]) dir_q[i] <= ctrl_bit;
      end
   end

   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> (out_q == $past(out_q)) && (dir_q == $past(dir_q))); // R9
   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !locked) |=> ((out_q & $past(wdata)) == $past(wdata))); // R6
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !locked) |=> ((out_q & $past(wdata)) == '0)); // R7
endmodule

// File: rtl/pwgpio_top.sv
module pwgpio_top
   import pwgpio_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_wr_en,
   input  logic                              bus_rd_en,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic [WORD_W-1:0]                 bus_wdata,
   output logic [WORD_W-1:0]                 bus_rdata,
   input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_in,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe
);
   localparam int unsigned NUM_PINS = NUM_BANKS * PINS_PER_BANK;

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("pwgpio_top: NUM_BANKS out of range");
   end

   logic [NUM_PINS-1:0]  in_sync, out_all, dir_all;
   logic [NUM_BANKS-1:0] set_hit, clr_hit, lock_hit, locked;
   logic [NUM_PINS-1:0]  ctrl_hit;
   logic                 key_hit;
   logic [WORD_W-1:0]    rd_mux;

   // write decode
   always_comb begin
      key_hit = bus_wr_en && (bus_addr == KEY_ADDR);
      for (int b = 0; b < NUM_BANKS; b++) begin
         set_hit[b]  = bus_wr_en && (bus_addr == SET_BASE  + ADDR_W'(b));
         clr_hit[b]  = bus_wr_en && (bus_addr == CLR_BASE  + ADDR_W'(b));
         lock_hit[b] = bus_wr_en && (bus_addr == LOCK_BASE + ADDR_W'(b));
      end
      for (int p = 0; p < NUM_PINS; p++)
         ctrl_hit[p] = bus_wr_en && (bus_addr == CTRL_BASE + ADDR_W'(p));
   end

   pwgpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync));

   pwgpio_lock #(.NUM_BANKS(NUM_BANKS)) u_lock (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .key_hit(key_hit),
      .lock_hit(lock_hit), .wdata(bus_wdata), .locked(locked));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      pwgpio_bank u_bank (
         .clk(clk), .rst_n(rst_n), .locked(locked[b]),
         .set_we(set_hit[b]), .clr_we(clr_hit[b]),
         .ctrl_we(ctrl_hit[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .ctrl_bit(bus_wdata[0]), .wdata(bus_wdata),
         .out_q(out_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .dir_q(dir_all[b*PINS_PER_BANK +: PINS_PER_BANK]));
   end

   assign pad_out = out_all;
   assign pad_oe  = ~dir_all;

   // read mux
   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == OUT_BASE + ADDR_W'(b))
            rd_mux = out_all[b*PINS_PER_BANK +: PINS_PER_BANK];
         if (bus_addr == IN_BASE + ADDR_W'(b))
            rd_mux = in_sync[b*PINS_PER_BANK +: PINS_PER_BANK];
         if (bus_addr == LOCK_BASE + ADDR_W'(b))
            rd_mux = {WORD_W{locked[b]}};
      end
      for (int p = 0; p < NUM_PINS; p++)
         if (bus_addr == CTRL_BASE + ADDR_W'(p))
            rd_mux = {{(WORD_W-1){1'b0}}, dir_all[p]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_mux;
   end
endmodule

// File: tb/sim_pwgpio_top.sv
`timescale 1ns/1ps
module sim_pwgpio_top;
   localparam int NB = 2;
   localparam int NP = NB * 32;
   localparam logic [8:0] A_OUT = 9'h000, A_IN = 9'h008, A_SET = 9'h010,
                          A_CLR = 9'h018, A_CTRL = 9'h040, A_LOCK = 9'h140,
                          A_KEY = 9'h148;
   localparam logic [31:0] KEY = 32'h00A5_A501;

   logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [8:0]    addr  = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] pin   = '0;
   logic [NP-1:0] pout, poe;

   always #10 clk = ~clk;

   pwgpio_top #(.NUM_BANKS(NB), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(wr), .bus_rd_en(rd),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .pad_in(pin), .pad_out(pout), .pad_oe(poe));

   int vecs = 0, bad = 0;
   logic [NP-1:0] m_out = '0;
   logic [NP-1:0] m_dir = '1;
   logic [31:0]   r;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      vecs++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr_w(logic [8:0] a, logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_w(logic [8:0] a, output logic [31:0] d);
      @(negedge clk); rd = 1'b1; addr = a;
      @(negedge clk); rd = 1'b0; d = rdata;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      vecs++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1", "pad_out", 64'(pout), 64'(m_out));
      chk("R1", "pad_oe", 64'(poe), 64'h0);
      for (int b = 0; b < NB; b++) begin
         rd_w(A_LOCK + 9'(b), r); chk("R1", "lock reg", 64'(r), 64'hFFFF_FFFF);
      end
      rd_w(A_CTRL + 9'd0, r);  chk("R1", "ctrl 0", 64'(r), 64'h1);
      rd_w(A_CTRL + 9'd63, r); chk("R1", "ctrl 63", 64'(r), 64'h1);

      // R9 writes to a locked bank are dropped
      wr_w(A_SET, 32'hFFFF_FFFF);
      wr_w(A_CTRL + 9'd5, 32'h0);
      chk("R9", "locked set", 64'(pout), 64'h0);
      chk("R9", "locked ctrl", 64'(poe), 64'h0);

      // R4 arming rules
      wr_w(A_LOCK, 32'h0);
      rd_w(A_LOCK, r); chk("R4", "unarmed lock write", 64'(r), 64'hFFFF_FFFF);
      wr_w(A_KEY, KEY); wr_w(A_SET, 32'h1); wr_w(A_LOCK, 32'h0);
      rd_w(A_LOCK, r); chk("R4", "intervening write", 64'(r), 64'hFFFF_FFFF);
      wr_w(A_KEY, 32'h00A5_A500); wr_w(A_LOCK, 32'h0);
      rd_w(A_LOCK, r); chk("R4", "wrong key", 64'(r), 64'hFFFF_FFFF);

      // R5 malformed lock word consumes the arm
      wr_w(A_KEY, KEY); wr_w(A_LOCK, 32'h0000_0001);
      rd_w(A_LOCK, r); chk("R5", "odd lock word", 64'(r), 64'hFFFF_FFFF);
      wr_w(A_LOCK, 32'h0);
      rd_w(A_LOCK, r); chk("R5", "arm consumed", 64'(r), 64'hFFFF_FFFF);

      // R3 unlock both banks
      for (int b = 0; b < NB; b++) begin
         wr_w(A_KEY, KEY); wr_w(A_LOCK + 9'(b), 32'h0);
         rd_w(A_LOCK + 9'(b), r); chk("R3", "unlock", 64'(r), 64'h0);
      end

      // R2 R6 per-pin set sweep
      for (int p = 0; p < NP; p++) begin
         wr_w(A_SET + 9'(p >> 5), 32'h1 << (p & 31));
         m_out[p] = 1'b1;
         chk("R2_R6", "set sweep", 64'(pout), 64'(m_out));
      end
      // R7 per-pin clear sweep, descending
      for (int p = NP - 1; p >= 0; p--) begin
         wr_w(A_CLR + 9'(p >> 5), 32'h1 << (p & 31));
         m_out[p] = 1'b0;
         chk("R2_R7", "clear sweep", 64'(pout), 64'(m_out));
      end
      // R6 R7 patterns keep untouched bits
      for (int k = 0; k < 4; k++) begin
         logic [31:0] sp = 32'hA5A5_A5A5 ^ (32'h1111_1111 * k);
         logic [31:0] cp = 32'h0F0F_0F0F << k;
         for (int b = 0; b < NB; b++) begin
            wr_w(A_SET + 9'(b), sp);
            m_out[b*32 +: 32] = m_out[b*32 +: 32] | sp;
            rd_w(A_OUT + 9'(b), r); chk("R6", "pattern set", 64'(r), 64'(m_out[b*32 +: 32]));
            wr_w(A_CLR + 9'(b), cp);
            m_out[b*32 +: 32] = m_out[b*32 +: 32] & ~cp;
            rd_w(A_OUT + 9'(b), r); chk("R7", "pattern clr", 64'(r), 64'(m_out[b*32 +: 32]));
         end
      end

      // R8 direction control
      for (int p = 0; p < NP; p += 7) begin
         wr_w(A_CTRL + 9'(p), 32'hFFFF_FFFE);
         m_dir[p] = 1'b0;
         chk("R8", "pad_oe out", 64'(poe), 64'(~m_dir));
         rd_w(A_CTRL + 9'(p), r); chk("R8", "ctrl read out", 64'(r), 64'h0);
         if (p % 2 == 0) begin
            wr_w(A_CTRL + 9'(p), 32'h0000_0001);
            m_dir[p] = 1'b1;
            rd_w(A_CTRL + 9'(p), r); chk("R8", "ctrl read in", 64'(r), 64'h1);
         end
      end
      chk("R8", "pad_oe final", 64'(poe), 64'(~m_dir));

      // R9 relock bank 1, bank 0 still works
      wr_w(A_KEY, KEY); wr_w(A_LOCK + 9'd1, 32'hFFFF_FFFF);
      rd_w(A_LOCK + 9'd1, r); chk("R9", "relock", 64'(r), 64'hFFFF_FFFF);
      wr_w(A_SET + 9'd1, 32'hFFFF_FFFF);
      wr_w(A_CLR + 9'd1, 32'hFFFF_FFFF);
      wr_w(A_CTRL + 9'd40, 32'h0);
      wr_w(A_SET, 32'h8000_0001);
      m_out[31] = 1'b1; m_out[0] = 1'b1;
      chk("R9", "pad_out mixed", 64'(pout), 64'(m_out));
      chk("R9", "pad_oe mixed", 64'(poe), 64'(~m_dir));
      rd_w(A_OUT + 9'd1, r); chk("R9", "read locked", 64'(r), 64'(m_out[63:32]));

      // R10 two-flop synchroniser timing
      @(negedge clk);
      pin = 64'h1234_5678_9ABC_DEF0; rd = 1'b1; addr = A_IN;
      @(negedge clk); chk("R10", "edge k", 64'(rdata), 64'h0);
      @(negedge clk); chk("R10", "edge k+1", 64'(rdata), 64'h0);
      @(negedge clk); chk("R10", "edge k+2", 64'(rdata), 64'h9ABC_DEF0);
      rd = 1'b0;
      rd_w(A_IN + 9'd1, r); chk("R10", "bank1 in", 64'(r), 64'h1234_5678);

      // R11 read-zero registers, ignored output write
      rd_w(A_SET, r);  chk("R11", "set reads 0", 64'(r), 64'h0);
      rd_w(A_CLR + 9'd1, r); chk("R11", "clr reads 0", 64'(r), 64'h0);
      rd_w(A_KEY, r);  chk("R11", "key reads 0", 64'(r), 64'h0);
      rd_w(9'h0F0, r); chk("R11", "unmapped", 64'(r), 64'h0);
      wr_w(A_OUT, 32'h5555_5555);
      chk("R11", "out write ignored", 64'(pout), 64'(m_out));
      @(negedge clk);
      chk("R11", "rdata holds", 64'(rdata), 64'h0);

      finish_run();
   end
endmodule